// File: doc/BRIEF.md
# DRAM Clock-Enable Power-Down Controller

This block drives the clock-enable line of one DRAM channel. It watches the pending-request flag from the command scheduler and counts idle cycles. When the idle count reaches a threshold, it lowers clock-enable and enters one of three low states. Which state it picks depends on the per-bank open status, a five-way policy field, a package deep-idle indication and a display permission bit.

Precharge power-down is used when every bank is closed, and active power-down when any bank is open. Self-refresh is used only in the most permissive policy, and only while the package sits in deep idle with display permission and all banks closed.

A minimum low time must elapse before an exit is honoured. An exit then holds a busy flag for a programmed latency before commands resume. A one-cycle strobe marks both entry into and exit from self-refresh, so the command path can issue the matching DRAM command. The pin output-enable is cleared when the rank is absent.

Top module: `cke_pd_ctrl`

## Requirements
- R1: After reset, cke_o is 1, busy_o is 0, sr_cmd_o is 0 and state_o reads 0. The state codes are: 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh, 4 exit.
- R2: With idle threshold T, the controller leaves active on the (T+1)th consecutive rising edge at which req_pending_i is sampled low, and not before. The idle count saturates at its maximum, so T equal to that maximum is still reached.
- R3: Leaving active with every bank closed gives state 1 when pd_mode_i is 1, 3 or 4, unless R6 applies.
- R4: Leaving active with at least one bank open gives state 2 when pd_mode_i is 2, 3 or 4.
- R5: Certain settings never leave active however long the idle time: pd_mode_i 0, or 5 to 7; pd_mode_i 1 with any bank open; pd_mode_i 2 with all banks closed.
- R6: With pd_mode_i 4, all banks closed, pkg_deep_idle_i 1 and sr_allow_i 1, the controller enters state 3, and sr_cmd_o is 1 for exactly the first cycle of state 3. If either gate input is 0, it enters state 1 instead.
- R7: Once in a low state (1, 2 or 3), cke_o stays 0 for at least min_low_i+1 cycles.
- R8: In state 1 or 2, a request observed after the minimum low time moves the controller to state 4. Clock-enable is 1 in state 4. State 4 lasts exit_lat_i+1 cycles, after which the controller returns to state 0.
- R9: State 3 is left when a request is pending or pkg_deep_idle_i is 0, once the minimum low time has passed. sr_cmd_o is 1 in the first cycle after leaving state 3.
- R10: busy_o is 1 in every state other than 0.
- R11: cke_oe_o equals rank_present_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_pending_i | input | 1 | Scheduler has a command waiting |
| bank_open_i | input | NUM_BANKS | One bit per bank, 1 while the bank is open |
| pd_mode_i | input | 3 | Power-down policy: 0 off, 1 precharge only, 2 active only, 3 both, 4 both plus self-refresh |
| pkg_deep_idle_i | input | 1 | Package is in a deep idle state |
| sr_allow_i | input | 1 | Display permits self-refresh |
| rank_present_i | input | 1 | Rank is populated |
| idle_thresh_i | input | CNT_W | Idle cycles before entry |
| min_low_i | input | CNT_W | Minimum low time, in cycles, minus one |
| exit_lat_i | input | CNT_W | Exit busy time, in cycles, minus one |
| cke_o | output | 1 | Clock-enable level |
| cke_oe_o | output | 1 | Clock-enable output enable |
| sr_cmd_o | output | 1 | Self-refresh entry/exit strobe |
| busy_o | output | 1 | Holds off new commands |
| state_o | output | 3 | Current state code |

## Verification
The bench builds the block with NUM_BANKS=4 and CNT_W=6. The narrow counter width lets a threshold of 63 hit the saturated idle count within a short directed run. It also lets random thresholds, minimum low times and exit latencies cover both small values and the counter ceiling. With four banks, random bank masks move often between all-closed and partly-open. That exercises the precharge, active and self-refresh choices under every policy value, including the unused codes 5 to 7.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;
  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_PPD  = 3'd1,
    ST_APD  = 3'd2,
    ST_SR   = 3'd3,
    ST_EXIT = 3'd4
  } pd_state_e;

  localparam logic [2:0] MODE_OFF     = 3'd0;
  localparam logic [2:0] MODE_PPD     = 3'd1;
  localparam logic [2:0] MODE_APD     = 3'd2;
  localparam logic [2:0] MODE_BOTH    = 3'd3;
  localparam logic [2:0] MODE_BOTH_SR = 3'd4;
endpackage

// File: rtl/cke_sat_timer.sv
module cke_sat_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cke_mode_sel.sv
module cke_mode_sel
  import cke_pd_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic [2:0]           mode_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 deep_idle_i,
  input  logic                 sr_allow_i,
  output pd_state_e            target_o,
  output logic                 valid_o
);
  logic any_open, allow_ppd, allow_apd, sr_ok;

  assign any_open  = |bank_open_i;
  assign allow_ppd = (mode_i == MODE_PPD) || (mode_i == MODE_BOTH) || (mode_i == MODE_BOTH_SR);
  assign allow_apd = (mode_i == MODE_APD) || (mode_i == MODE_BOTH) || (mode_i == MODE_BOTH_SR);
  assign sr_ok     = (mode_i == MODE_BOTH_SR) && deep_idle_i && sr_allow_i;

  always_comb begin
    target_o = ST_ACT;
    valid_o  = 1'b0;
    if (any_open) begin
      if (allow_apd) begin
        target_o = ST_APD;
        valid_o  = 1'b1;
      end
    end else if (sr_ok) begin
      target_o = ST_SR;
      valid_o  = 1'b1;
    end else if (allow_ppd) begin
      target_o = ST_PPD;
      valid_o  = 1'b1;
    end
  end
endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
  import cke_pd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_pending_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic [2:0]           pd_mode_i,
  input  logic                 pkg_deep_idle_i,
  input  logic                 sr_allow_i,
  input  logic                 rank_present_i,
  input  logic [CNT_W-1:0]     idle_thresh_i,
  input  logic [CNT_W-1:0]     min_low_i,
  input  logic [CNT_W-1:0]     exit_lat_i,
  output logic                 cke_o,
  output logic                 cke_oe_o,
  output logic                 sr_cmd_o,
  output logic                 busy_o,
  output logic [2:0]           state_o
);
  pd_state_e        st_q, st_d, tgt;
  logic             tgt_vld, in_low, low_ok;
  logic [CNT_W-1:0] idle_q, low_q, ex_q, ex_d;
  logic             sr_cmd_q;

  assign in_low = (st_q == ST_PPD) || (st_q == ST_APD) || (st_q == ST_SR);

  cke_sat_timer #(.W(CNT_W)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (req_pending_i || (st_q != ST_ACT)),
    .cnt_o  (idle_q)
  );

  cke_sat_timer #(.W(CNT_W)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_low),
    .cnt_o  (low_q)
  );

  cke_mode_sel #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .mode_i      (pd_mode_i),
    .bank_open_i (bank_open_i),
    .deep_idle_i (pkg_deep_idle_i),
    .sr_allow_i  (sr_allow_i),
    .target_o    (tgt),
    .valid_o     (tgt_vld)
  );

  assign low_ok = (low_q >= min_low_i);

  always_comb begin
    st_d = st_q;
    ex_d = ex_q;
    unique case (st_q)
      ST_ACT: if (!req_pending_i && (idle_q >= idle_thresh_i) && tgt_vld) st_d = tgt;
      ST_PPD, ST_APD: if (req_pending_i && low_ok) begin
        st_d = ST_EXIT;
        ex_d = exit_lat_i;
      end
      ST_SR: if ((req_pending_i || !pkg_deep_idle_i) && low_ok) begin
        st_d = ST_EXIT;
        ex_d = exit_lat_i;
      end
      ST_EXIT: if (ex_q == '0) st_d = ST_ACT;
               else ex_d = ex_q - 1'b1;
      default: st_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_ACT;
      ex_q     <= '0;
      sr_cmd_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      ex_q     <= ex_d;
      sr_cmd_q <= (st_d == ST_SR) != (st_q == ST_SR);
    end
  end

  assign cke_o    = (st_q == ST_ACT) || (st_q == ST_EXIT);
  assign busy_o   = (st_q != ST_ACT);
  assign sr_cmd_o = sr_cmd_q;
  assign cke_oe_o = rank_present_i;
  assign state_o  = st_q;

  assert_idle_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> ($past(idle_q) >= $past(idle_thresh_i)) && !$past(req_pending_i));

  assert_ppd_closed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PPD && $past(st_q) == ST_ACT) |-> ($past(bank_open_i) == '0));

  assert_apd_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_APD && $past(st_q) == ST_ACT) |-> $past(|bank_open_i));

  assert_mode_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> ($past(pd_mode_i) != 3'd0) && ($past(pd_mode_i) <= 3'd4));

  assert_sr_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SR && $past(st_q) == ST_ACT) |->
      ($past(pkg_deep_idle_i) && $past(sr_allow_i) && $past(pd_mode_i) == MODE_BOTH_SR));

  assert_min_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> ($past(low_q) >= $past(min_low_i)));

  assert_exit_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> busy_o);

  assert_sr_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_cmd_o |-> ((st_q == ST_SR) != ($past(st_q) == ST_SR)));
endmodule

// File: tb/cke_pd_ctrl_bench.sv
`timescale 1ns/1ps
module cke_pd_ctrl_bench;
  localparam int NB  = 4;
  localparam int CW  = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b1;
  logic [NB-1:0] banks = '0;
  logic [2:0]    mode = 3'd0;
  logic          deep = 1'b0, disp = 1'b0, rank = 1'b1;
  logic [CW-1:0] thr = '0, mlow = '0, elat = '0;
  logic          cke, cke_oe, sr_cmd, busy;
  logic [2:0]    state;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cke_pd_ctrl #(.NUM_BANKS(NB), .CNT_W(CW)) u_cke_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_pending_i(req), .bank_open_i(banks),
    .pd_mode_i(mode), .pkg_deep_idle_i(deep), .sr_allow_i(disp),
    .rank_present_i(rank), .idle_thresh_i(thr), .min_low_i(mlow),
    .exit_lat_i(elat), .cke_o(cke), .cke_oe_o(cke_oe), .sr_cmd_o(sr_cmd),
    .busy_o(busy), .state_o(state)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: which low state the policy permits (0 = none)
  function automatic int pick(int md, int bk, bit dp, bit ds);
    bit ppd_ok = (md == 1) || (md == 3) || (md == 4);
    bit apd_ok = (md == 2) || (md == 3) || (md == 4);
    if (bk != 0) return apd_ok ? 2 : 0;
    if (md == 4 && dp && ds) return 3;
    return ppd_ok ? 1 : 0;
  endfunction

  int m_st = 0, m_idle = 0, m_low = 0, m_ex = 0;
  bit m_sr = 1'b0;
  int nx, ex_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_idle <= 0; m_low <= 0; m_ex <= 0; m_sr <= 1'b0;
    end else begin
      nx = m_st; ex_n = m_ex;
      if (m_st == 0) begin
        if (!req && m_idle >= int'(thr)) nx = pick(int'(mode), int'(banks), deep, disp);
      end else if (m_st == 4) begin
        if (m_ex == 0) nx = 0; else ex_n = m_ex - 1;
      end else begin
        if ((req || (m_st == 3 && !deep)) && m_low >= int'(mlow)) begin
          nx = 4; ex_n = int'(elat);
        end
      end
      m_sr   <= (nx == 3) != (m_st == 3);
      m_idle <= (req || m_st != 0) ? 0 : (m_idle < MAXC ? m_idle + 1 : MAXC);
      m_low  <= (m_st >= 1 && m_st <= 3) ? (m_low < MAXC ? m_low + 1 : MAXC) : 0;
      m_st   <= nx;
      m_ex   <= ex_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 busy", int'(busy), int'(m_st != 0));
      check("R3/R4/R6 state", int'(state), m_st);
      check("R7/R8 cke", int'(cke), int'(m_st == 0 || m_st == 4));
      check("R9 sr_cmd", int'(sr_cmd), int'(m_sr));
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    check("R1 reset cke", int'(cke), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset state", int'(state), 0);
    check("R1 reset sr_cmd", int'(sr_cmd), 0);
    rst_n = 1'b1;
    tick(2);

    // R2/R3/R7/R8 directed: T=3, M=2, L=1
    mode = 3'd1; banks = '0; thr = 6'd3; mlow = 6'd2; elat = 6'd1;
    tick(1);
    req = 1'b0;
    tick(3);
    check("R2 still active before threshold", int'(cke), 1);
    tick(1);
    check("R3 precharge power-down", int'(state), 1);
    check("R10 busy in low state", int'(busy), 1);
    req = 1'b1;
    tick(2);
    check("R7 held low during minimum", int'(cke), 0);
    tick(1);
    check("R8 exit state", int'(state), 4);
    check("R8 cke high in exit", int'(cke), 1);
    check("R8 busy in exit", int'(busy), 1);
    tick(1);
    check("R8 still exit for latency", int'(state), 4);
    tick(1);
    check("R8 back to active", int'(state), 0);
    check("R8 busy released", int'(busy), 0);

    // R4 directed
    mode = 3'd2; banks = 4'b0010; thr = '0; mlow = '0; elat = '0;
    req = 1'b0;
    tick(1);
    check("R4 active power-down", int'(state), 2);
    req = 1'b1;
    tick(1);
    check("R8 exit from active pd", int'(state), 4);
    tick(1);
    check("R8 one-cycle exit", int'(state), 0);

    // R5 directed
    mode = 3'd0; banks = '0; req = 1'b0;
    tick(20);
    check("R5 mode off", int'(state), 0);
    mode = 3'd1; banks = 4'b1000;
    tick(20);
    check("R5 precharge-only with open bank", int'(state), 0);
    mode = 3'd2; banks = '0;
    tick(20);
    check("R5 active-only with banks closed", int'(state), 0);
    mode = 3'd7;
    tick(20);
    check("R5 unused code", int'(cke), 1);

    // R6/R9 directed
    req = 1'b1; tick(1);
    mode = 3'd4; deep = 1'b1; disp = 1'b1; banks = '0;
    req = 1'b0;
    tick(1);
    check("R6 self-refresh", int'(state), 3);
    check("R6 entry strobe", int'(sr_cmd), 1);
    tick(1);
    check("R6 strobe one cycle", int'(sr_cmd), 0);
    deep = 1'b0;
    tick(1);
    check("R9 wake on deep idle loss", int'(state), 4);
    check("R9 exit strobe", int'(sr_cmd), 1);
    req = 1'b1;
    tick(2);
    deep = 1'b1; disp = 1'b0; req = 1'b0;
    tick(1);
    check("R6 display veto falls back", int'(state), 1);
    req = 1'b1;
    tick(3);

    // R2 saturation at T = max
    mode = 3'd1; disp = 1'b0; deep = 1'b0; thr = 6'd63;
    req = 1'b0;
    tick(63);
    check("R2 not yet at saturated threshold", int'(state), 0);
    tick(1);
    check("R2 entry at saturated threshold", int'(state), 1);
    req = 1'b1;
    tick(3);

    // R11
    rank = 1'b0; #1;
    check("R11 oe cleared", int'(cke_oe), 0);
    rank = 1'b1; #1;
    check("R11 oe set", int'(cke_oe), 1);

    // random phase
    begin
      int pct = 20;
      for (int i = 0; i < 30000; i++) begin
        @(negedge clk);
        if (i % 400 == 0) begin
          mode = 3'($urandom_range(0, 7));
          thr  = ($urandom_range(0, 9) == 0) ? 6'd63 : 6'($urandom_range(0, 7));
          mlow = 6'($urandom_range(0, 5));
          elat = 6'($urandom_range(0, 4));
          case ($urandom_range(0, 2))
            0: pct = 2;
            1: pct = 20;
            default: pct = 60;
          endcase
        end
        req = ($urandom_range(0, 99) < pct);
        if ($urandom_range(0, 9) == 0)
          banks = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : '0;
        if ($urandom_range(0, 19) == 0) deep = ~deep;
        if ($urandom_range(0, 29) == 0) disp = ~disp;
        if ($urandom_range(0, 19) == 0) begin
          rank = 1'($urandom_range(0, 1));
          #1 check("R11 oe follows rank", int'(cke_oe), int'(rank));
        end
      end
    end

    tick(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule